// File: doc/BRIEF.md
# ACPI Event Status and SCI Controller

This block holds the power-management event state of a platform and turns it into the level-sensitive system control interrupt (SCI). Four fixed-function events (timer overflow, global lock, power button, real-time clock) latch into a 16-bit PM1 status register. A general-purpose event (GPE) block latches hotplug and other strobes. The GPE block is 2·GPE_BYTES bytes long, with its status bytes first and its enable bytes after them. Every status bit is cleared by writing a one to it. Every enable bit is plain read/write.

Firmware and the OS reach the registers through a byte-wide register bus. The bus accepts a request every cycle and returns read data one cycle later. Writing a command byte to the APM control port switches the SCI-enable flag on or off. When the SMI control byte allows it, the same write also fires a one-cycle system-management interrupt (SMI) pulse. The free-running PM timer counter sits outside the block and delivers only its overflow strobe. The block reports whether that strobe is currently armed.

Top module: `acpi_sci_ctrl`

## Requirements
- R1: After reset, all PM1 and GPE status and enable bits, the SCI-enable flag and the SMI control byte read as zero, and `sci`, `smi` and `tmr_armed` are low.
- R2: PM1 event bits sit at timer = bit 0, global lock = bit 5, power button = bit 8, RTC = bit 10. PM1 status reads at address 0x0 (low byte) and 0x1 (high byte), and PM1 enable reads at 0x2 and 0x3. `sci` is high whenever PM1 status AND PM1 enable is nonzero in any of these four bits.
- R3: Only the four event bit positions of PM1 enable are writable; writing 0xFF to both enable bytes reads back 0x21 and 0x05.
- R4: GPE status byte i is at 0x8+i and GPE enable byte i at 0x8+GPE_BYTES+i (0x8, 0x9 status; 0xA, 0xB enable by default); `ev_gpe` bit k sets status bit k. `sci` is also high when GPE status byte 0 AND enable byte 0 is nonzero; bytes above 0 never drive `sci`.
- R5: Writing a one to a status bit clears it, writing zero leaves it; an event arriving in the same cycle as its clear leaves the bit set.
- R6: `tmr_armed` is high exactly when the timer enable bit is set and timer status is clear; a timer overflow strobe sets timer status only while armed.
- R7: Writing 0xF1 to the APM port (0x6) sets the SCI-enable flag (bit 0 of address 0x4), 0xF0 clears it, any other value leaves it; 0x6 reads back the last command, and writes to 0x4 have no effect.
- R8: Any APM port write while bit 1 of the SMI control byte (address 0x5) is set makes `smi` high for exactly the next cycle; with that bit clear `smi` stays low.
- R9: A power-down request (`ev_pwrbtn`) sets the power-button status bit.
- R10: `bus_ready` is always high; `rsp_valid` is high for the one cycle after an accepted read and never after a write; unmapped addresses read 0 and ignore writes.
- R11: `sci` reflects a register write or an event strobe in the cycle right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 8 | Read data |
| ev_tmr_ovf | input | 1 | PM timer overflow strobe |
| ev_glbl | input | 1 | Global lock release strobe |
| ev_pwrbtn | input | 1 | Power button / power-down request strobe |
| ev_rtc | input | 1 | RTC alarm strobe |
| ev_gpe | input | GPE_BYTES*8 | General-purpose event strobes |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | System-management interrupt pulse |
| tmr_armed | output | 1 | Timer overflow currently armed |

## Verification
A wrong status or enable bit shows on `sci` in the very next cycle, since the level comes straight from the registers. A bit that is stuck or not latched also shows on a readback of its byte two cycles after the request. A broken arming term shows at once on `tmr_armed`, and a missed timer overflow shows on `sci`. A bad APM decode shows on the SCI-enable readback. A bad SMI gate shows as a missing, extra or too long pulse in the cycle after the port write.

// File: rtl/acpi_evt_pkg.sv
package acpi_evt_pkg;
  localparam int ADDR_W = 4;
  localparam int PM1_W  = 16;

  localparam logic [ADDR_W-1:0] A_PM1_STS_LO = 4'h0;
  localparam logic [ADDR_W-1:0] A_PM1_STS_HI = 4'h1;
  localparam logic [ADDR_W-1:0] A_PM1_EN_LO  = 4'h2;
  localparam logic [ADDR_W-1:0] A_PM1_EN_HI  = 4'h3;
  localparam logic [ADDR_W-1:0] A_PM1_CTL    = 4'h4;
  localparam logic [ADDR_W-1:0] A_SMI_CTL    = 4'h5;
  localparam logic [ADDR_W-1:0] A_APM_PORT   = 4'h6;
  localparam int                A_GPE_BASE   = 8;

  localparam int B_TMR    = 0;
  localparam int B_GLBL   = 5;
  localparam int B_PWRBTN = 8;
  localparam int B_RTC    = 10;

  localparam logic [PM1_W-1:0] PM1_EVT_MASK =
      (PM1_W'(1) << B_TMR) | (PM1_W'(1) << B_GLBL) |
      (PM1_W'(1) << B_PWRBTN) | (PM1_W'(1) << B_RTC);

  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;
  localparam int         SMI_GATE_BIT = 1;

  typedef struct packed {
    logic tmr;
    logic glbl;
    logic pwrbtn;
    logic rtc;
  } pm1_evt_t;
endpackage

// File: rtl/acpi_pm1_regs.sv
module acpi_pm1_regs
  import acpi_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sts_lo,
  input  logic             wr_sts_hi,
  input  logic             wr_en_lo,
  input  logic             wr_en_hi,
  input  logic [7:0]       wdata,
  input  pm1_evt_t         evt,
  output logic [PM1_W-1:0] sts,
  output logic [PM1_W-1:0] en,
  output logic             sci_src,
  output logic             tmr_armed
);
  logic [PM1_W-1:0] clr_v, set_v, sts_nxt, en_nxt;

  assign tmr_armed = en[B_TMR] & ~sts[B_TMR];
  assign sci_src   = |(sts & en & PM1_EVT_MASK);

  always_comb begin
    clr_v = '0;
    if (wr_sts_lo) clr_v[7:0]  = wdata;
    if (wr_sts_hi) clr_v[15:8] = wdata;
    set_v = '0;
    set_v[B_TMR]    = evt.tmr & tmr_armed;
    set_v[B_GLBL]   = evt.glbl;
    set_v[B_PWRBTN] = evt.pwrbtn;
    set_v[B_RTC]    = evt.rtc;
    sts_nxt = ((sts & ~clr_v) | set_v) & PM1_EVT_MASK;
    en_nxt = en;
    if (wr_en_lo) en_nxt[7:0]  = wdata;
    if (wr_en_hi) en_nxt[15:8] = wdata;
    en_nxt = en_nxt & PM1_EVT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= sts_nxt;
      en  <= en_nxt;
    end
  end

  a_r6_armed_overflow_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.tmr && tmr_armed) |=> sts[B_TMR]);
  a_r6_unarmed_overflow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.tmr && !en[B_TMR] && !sts[B_TMR]) |=> !sts[B_TMR]);
  a_r9_pwrbtn_latches: assert property (@(posedge clk) disable iff (!rst_n)
    evt.pwrbtn |=> sts[B_PWRBTN]);
  a_r5_rtc_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts_hi && wdata[B_RTC-8] && !evt.rtc) |=> !sts[B_RTC]);
  a_r5_rtc_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rtc |=> sts[B_RTC]);
endmodule

// File: rtl/acpi_gpe_block.sv
module acpi_gpe_block #(
  parameter int GPE_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GPE_BYTES-1:0]   wr_sts,
  input  logic [GPE_BYTES-1:0]   wr_en,
  input  logic [7:0]             wdata,
  input  logic [GPE_BYTES*8-1:0] ev,
  output logic [GPE_BYTES*8-1:0] sts,
  output logic [GPE_BYTES*8-1:0] en,
  output logic                   sci_src
);
  for (genvar g = 0; g < GPE_BYTES; g++) begin : g_byte
    logic [7:0] s_q, e_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        e_q <= '0;
      end else begin
        s_q <= (s_q & ~(wr_sts[g] ? wdata : 8'h00)) | ev[g*8 +: 8];
        if (wr_en[g]) e_q <= wdata;
      end
    end
    assign sts[g*8 +: 8] = s_q;
    assign en[g*8 +: 8]  = e_q;

    a_r4_gpe_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      ev[g*8] |=> s_q[0]);
    a_r5_gpe_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts[g] && wdata[0] && !ev[g*8]) |=> !s_q[0]);
  end

  // Only byte 0 participates in the interrupt level.
  assign sci_src = |(sts[7:0] & en[7:0]);
endmodule

// File: rtl/acpi_apm_port.sv
module acpi_apm_port
  import acpi_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       smi_gate,
  output logic       sci_en,
  output logic [7:0] last_cmd,
  output logic       smi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_en   <= 1'b0;
      last_cmd <= '0;
      smi      <= 1'b0;
    end else begin
      smi <= we & smi_gate;
      if (we) begin
        last_cmd <= wdata;
        if (wdata == CMD_SCI_ON)       sci_en <= 1'b1;
        else if (wdata == CMD_SCI_OFF) sci_en <= 1'b0;
      end
    end
  end

  a_r7_cmd_on: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == CMD_SCI_ON) |=> sci_en);
  a_r7_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == CMD_SCI_OFF) |=> !sci_en);
  a_r8_smi_needs_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(we && smi_gate));
  a_r8_smi_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && smi_gate) |=> smi);
endmodule

// File: rtl/acpi_sci_ctrl.sv
module acpi_sci_ctrl
  import acpi_evt_pkg::*;
#(
  parameter int GPE_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  output logic                   bus_ready,
  input  logic                   bus_write,
  input  logic [3:0]             bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_rdata,
  input  logic                   ev_tmr_ovf,
  input  logic                   ev_glbl,
  input  logic                   ev_pwrbtn,
  input  logic                   ev_rtc,
  input  logic [GPE_BYTES*8-1:0] ev_gpe,
  output logic                   sci,
  output logic                   smi,
  output logic                   tmr_armed
);
  localparam int GPE_BITS = GPE_BYTES * 8;
  localparam int GPE_EN_BASE = A_GPE_BASE + GPE_BYTES;

  logic acc_wr, acc_rd, any_evt;
  logic [PM1_W-1:0] pm1_sts, pm1_en;
  logic [GPE_BITS-1:0] gpe_sts, gpe_en;
  logic [GPE_BYTES-1:0] gpe_wr_sts, gpe_wr_en;
  logic pm1_sci, gpe_sci, sci_en, apm_we;
  logic [7:0] apm_cmd, smi_ctl, rd_mux;
  pm1_evt_t evt;

  assign bus_ready = 1'b1;
  assign acc_wr = bus_valid & bus_write;
  assign acc_rd = bus_valid & ~bus_write;
  assign apm_we = acc_wr && (bus_addr == A_APM_PORT);
  assign evt = '{tmr: ev_tmr_ovf, glbl: ev_glbl, pwrbtn: ev_pwrbtn, rtc: ev_rtc};
  assign any_evt = ev_tmr_ovf | ev_glbl | ev_pwrbtn | ev_rtc | (|ev_gpe);

  for (genvar g = 0; g < GPE_BYTES; g++) begin : g_dec
    assign gpe_wr_sts[g] = acc_wr && (bus_addr == ADDR_W'(A_GPE_BASE + g));
    assign gpe_wr_en[g]  = acc_wr && (bus_addr == ADDR_W'(GPE_EN_BASE + g));
  end

  acpi_pm1_regs u_pm1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sts_lo (acc_wr && bus_addr == A_PM1_STS_LO),
    .wr_sts_hi (acc_wr && bus_addr == A_PM1_STS_HI),
    .wr_en_lo  (acc_wr && bus_addr == A_PM1_EN_LO),
    .wr_en_hi  (acc_wr && bus_addr == A_PM1_EN_HI),
    .wdata     (bus_wdata),
    .evt       (evt),
    .sts       (pm1_sts),
    .en        (pm1_en),
    .sci_src   (pm1_sci),
    .tmr_armed (tmr_armed)
  );

  acpi_gpe_block #(.GPE_BYTES(GPE_BYTES)) u_gpe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sts  (gpe_wr_sts),
    .wr_en   (gpe_wr_en),
    .wdata   (bus_wdata),
    .ev      (ev_gpe),
    .sts     (gpe_sts),
    .en      (gpe_en),
    .sci_src (gpe_sci)
  );

  acpi_apm_port u_apm (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (apm_we),
    .wdata    (bus_wdata),
    .smi_gate (smi_ctl[SMI_GATE_BIT]),
    .sci_en   (sci_en),
    .last_cmd (apm_cmd),
    .smi      (smi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_ctl <= '0;
    else if (acc_wr && bus_addr == A_SMI_CTL) smi_ctl <= bus_wdata;
  end

  assign sci = pm1_sci | gpe_sci;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_PM1_STS_LO: rd_mux = pm1_sts[7:0];
      A_PM1_STS_HI: rd_mux = pm1_sts[15:8];
      A_PM1_EN_LO:  rd_mux = pm1_en[7:0];
      A_PM1_EN_HI:  rd_mux = pm1_en[15:8];
      A_PM1_CTL:    rd_mux = {7'b0, sci_en};
      A_SMI_CTL:    rd_mux = smi_ctl;
      A_APM_PORT:   rd_mux = apm_cmd;
      default:      rd_mux = '0;
    endcase
    for (int i = 0; i < GPE_BYTES; i++) begin
      if (bus_addr == ADDR_W'(A_GPE_BASE + i))  rd_mux = gpe_sts[i*8 +: 8];
      if (bus_addr == ADDR_W'(GPE_EN_BASE + i)) rd_mux = gpe_en[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_rdata <= rd_mux;
    end
  end

  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc_rd));
  a_r10_read_gets_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);
  a_r11_sci_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> $past(any_evt || acc_wr));
  a_r11_sci_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sci) |-> $past(acc_wr));
endmodule

// File: tb/sim_acpi_sci_ctrl.sv
`timescale 1ns/1ps
module sim_acpi_sci_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic ev_tmr_ovf = 0, ev_glbl = 0, ev_pwrbtn = 0, ev_rtc = 0;
  logic [15:0] ev_gpe = '0;
  logic bus_ready, rsp_valid, sci, smi, tmr_armed;
  logic [7:0] rsp_rdata;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  acpi_sci_ctrl #(.GPE_BYTES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ev_tmr_ovf(ev_tmr_ovf),
    .ev_glbl(ev_glbl), .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc), .ev_gpe(ev_gpe),
    .sci(sci), .smi(smi), .tmr_armed(tmr_armed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic v);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 0;
    v = rsp_valid; d = rsp_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d; logic v;
    rd(a, d, v);
    chk({tag, " rsp_valid"}, 32'(v), 32'd1);
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic pulse_tick();
    @(posedge clk); @(negedge clk);
    ev_tmr_ovf = 0; ev_glbl = 0; ev_pwrbtn = 0; ev_rtc = 0; ev_gpe = '0;
  endtask

  task automatic t_reset();
    chk("R1 sci", 32'(sci), 0);
    chk("R1 smi", 32'(smi), 0);
    chk("R1 tmr_armed", 32'(tmr_armed), 0);
    chk("R10 bus_ready", 32'(bus_ready), 1);
    for (int a = 0; a < 12; a++) rd_chk("R1 reg zero", 4'(a), 8'h00);
  endtask

  task automatic t_pm1_sources();
    wr(4'h2, 8'h20);
    ev_glbl = 1;
    chk("R11 sci before edge", 32'(sci), 0);
    pulse_tick();
    chk("R2 glbl sci", 32'(sci), 1);
    rd_chk("R2 glbl status", 4'h0, 8'h20);
    wr(4'h0, 8'h20);
    chk("R5 glbl cleared sci", 32'(sci), 0);
    ev_rtc = 1; pulse_tick();
    chk("R2 rtc without enable", 32'(sci), 0);
    rd_chk("R2 rtc status", 4'h1, 8'h04);
    wr(4'h3, 8'h04);
    chk("R11 sci on enable write", 32'(sci), 1);
    wr(4'h1, 8'h00);
    chk("R5 zero write keeps", 32'(sci), 1);
    wr(4'h1, 8'h04);
    chk("R5 rtc cleared", 32'(sci), 0);
    wr(4'h2, 8'h00); wr(4'h3, 8'h00);
  endtask

  task automatic t_enable_mask();
    wr(4'h2, 8'hFF); wr(4'h3, 8'hFF);
    rd_chk("R3 enable lo mask", 4'h2, 8'h21);
    rd_chk("R3 enable hi mask", 4'h3, 8'h05);
    wr(4'h2, 8'h00); wr(4'h3, 8'h00);
  endtask

  task automatic t_set_wins();
    ev_rtc = 1; pulse_tick();
    bus_valid = 1; bus_write = 1; bus_addr = 4'h1; bus_wdata = 8'h04; ev_rtc = 1;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0; ev_rtc = 0;
    rd_chk("R5 set wins over clear", 4'h1, 8'h04);
    wr(4'h1, 8'h04);
    rd_chk("R5 cleared after", 4'h1, 8'h00);
  endtask

  task automatic t_timer();
    ev_tmr_ovf = 1; pulse_tick();
    rd_chk("R6 unarmed overflow ignored", 4'h0, 8'h00);
    wr(4'h2, 8'h01);
    chk("R6 armed", 32'(tmr_armed), 1);
    ev_tmr_ovf = 1; pulse_tick();
    chk("R6 overflow sci", 32'(sci), 1);
    chk("R6 disarmed by status", 32'(tmr_armed), 0);
    wr(4'h0, 8'h01);
    chk("R6 rearmed", 32'(tmr_armed), 1);
    chk("R6 sci cleared", 32'(sci), 0);
    wr(4'h2, 8'h00);
    chk("R6 disarmed by enable", 32'(tmr_armed), 0);
  endtask

  task automatic t_pwrbtn();
    wr(4'h3, 8'h01);
    ev_pwrbtn = 1; pulse_tick();
    chk("R9 power-down sci", 32'(sci), 1);
    rd_chk("R9 pwrbtn status", 4'h1, 8'h01);
    wr(4'h1, 8'h01); wr(4'h3, 8'h00);
    chk("R9 cleared", 32'(sci), 0);
  endtask

  task automatic t_gpe();
    wr(4'hA, 8'h02); wr(4'hB, 8'hFF);
    ev_gpe = 16'h0200; pulse_tick();
    chk("R4 byte1 no sci", 32'(sci), 0);
    rd_chk("R4 byte1 status", 4'h9, 8'h02);
    ev_gpe = 16'h0004; pulse_tick();
    chk("R4 unenabled bit no sci", 32'(sci), 0);
    ev_gpe = 16'h0002; pulse_tick();
    chk("R4 byte0 sci", 32'(sci), 1);
    rd_chk("R4 byte0 status", 4'h8, 8'h06);
    wr(4'hA, 8'h00);
    chk("R4 enable off sci", 32'(sci), 0);
    wr(4'hA, 8'h02);
    chk("R4 enable on sci", 32'(sci), 1);
    wr(4'h8, 8'h02);
    chk("R5 gpe clear sci", 32'(sci), 0);
    rd_chk("R5 gpe w1c", 4'h8, 8'h04);
    wr(4'h8, 8'hFF); wr(4'h9, 8'hFF);
    rd_chk("R4 enable readback", 4'hB, 8'hFF);
    wr(4'hA, 8'h00); wr(4'hB, 8'h00);
  endtask

  task automatic t_apm();
    wr(4'h4, 8'h01);
    rd_chk("R7 ctl write ignored", 4'h4, 8'h00);
    wr(4'h6, 8'hF1);
    rd_chk("R7 sci_en on", 4'h4, 8'h01);
    wr(4'h6, 8'h55);
    rd_chk("R7 other keeps", 4'h4, 8'h01);
    rd_chk("R7 last cmd", 4'h6, 8'h55);
    wr(4'h6, 8'hF0);
    rd_chk("R7 sci_en off", 4'h4, 8'h00);
  endtask

  task automatic t_smi();
    wr(4'h6, 8'h12);
    chk("R8 no smi ungated", 32'(smi), 0);
    wr(4'h5, 8'h02);
    rd_chk("R8 smi ctl readback", 4'h5, 8'h02);
    wr(4'h6, 8'h12);
    chk("R8 smi pulse", 32'(smi), 1);
    @(negedge clk);
    chk("R8 smi one cycle", 32'(smi), 0);
    wr(4'h5, 8'h00);
    wr(4'h6, 8'hF1);
    chk("R8 smi gated off", 32'(smi), 0);
    wr(4'h6, 8'hF0);
  endtask

  task automatic t_bus();
    wr(4'h7, 8'hAA);
    chk("R10 no rsp after write", 32'(rsp_valid), 0);
    rd_chk("R10 unmapped reads zero", 4'h7, 8'h00);
    rd_chk("R10 unmapped high", 4'hF, 8'h00);
    @(negedge clk);
    chk("R10 rsp one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pm1_sources();
    t_enable_mask();
    t_set_wins();
    t_timer();
    t_pwrbtn();
    t_gpe();
    t_apm();
    t_smi();
    t_bus();
    finish_run();
  end
endmodule